// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timing Unit

This block generates three complementary pairs of pulse-width-modulated outputs, one high-side and one low-side signal per phase. All three phases share one time base. A single up/down counter climbs through the first half of each period and descends through the second half, so every pulse is centred on the period midpoint. One half-period length and one dead-time value are shared by all phases, and each phase has its own duty value. The dead time is taken off both ends of the high-side window and added to both ends of the low-side gap. The two sides of a phase are therefore never active together.

Values are written over a plain register-write port into shadow copies. In single-update mode the shadow copies move into the active set once per period, at period start. In double-update mode they also move at mid-period, so the second half can use a new half-period length, dead time and duty. A one-cycle sync pulse marks the first cycle of each period, and a half flag shows which half is running. The first write of the half-period value starts the time base. Outputs, sync and the half flag stay low until the half-period value and all three duty values have each been written at least once.

The write port has no back-pressure: a write is taken on every clock edge where `wr_en` is high, and the port has no ready signal. Select codes: 0 is the half-period length, 1 is the dead time, and 2, 3 and 4 are the duties of phases 0, 1 and 2.

Top module: `cpwm3_top`

## Requirements
- R1: While `rst_n` is low, all six PWM outputs, `sync_pulse` and `half_flag` are 0.
- R2: Until the half-period value (code 0) and the duty values (codes 2, 3, 4) have each been written at least once, all PWM outputs, `sync_pulse` and `half_flag` stay 0. The dead time (code 1) is not needed for enable. After the last of these writes, normal output begins without a further write.
- R3: In single-update mode, with half-period P, dead time T and duty D, the high side of a phase is active for 2·clamp(D−T, 0, P) cycles per period.
- R4: Under the same conditions, the low side is active for 2·clamp(P−D−T, 0, P) cycles per period.
- R5: The high and low outputs of one phase are never both 1 in the same cycle.
- R6: In single-update mode a period lasts 2·P cycles. `sync_pulse` is 1 for exactly its first cycle. `half_flag` is 0 for the first P cycles and 1 for the last P cycles.
- R7: When the half-period value is written first while the time base is stopped, the first `sync_pulse` appears P + floor(P/2) cycles after the write edge in single-update mode, and P cycles after it in double-update mode.
- R8: In single-update mode, a value written while running takes effect only at the next period start; the active half-period never changes except at a period start.
- R9: In double-update mode, shadow values also load at mid-period: the second half uses the newly written half-period and duty, so that period lasts old P plus new P cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_mode | input | 1 | 1 selects double-update mode, 0 single-update mode |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | SW (3) | Register select code |
| wr_data | input | W (12) | Value to write |
| pwm_hi | output | NCH (3) | High-side outputs, one bit per phase |
| pwm_lo | output | NCH (3) | Low-side outputs, one bit per phase |
| sync_pulse | output | 1 | One-cycle pulse on the first cycle of each period |
| half_flag | output | 1 | 0 in the first half of the period, 1 in the second half |

## Verification
A counter that steps wrongly, or a half boundary compared against the wrong period value, shows at the ports within one half-period. `half_flag` then rises off its expected cycle, or the spacing between sync pulses departs from 2·P. A shadow value loaded at the wrong moment shows within one period: the pulse widths or the sync spacing keep old values for a period longer than they should, or change one period early. Dead-time or compare errors change the per-period high and low cycle counts of a phase at once, and any overlap of the two sides shows in the very cycle it happens.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int SEL_PERIOD    = 0;
  localparam int SEL_DEAD      = 1;
  localparam int SEL_DUTY_BASE = 2;

  typedef enum logic {PH_UP = 1'b0, PH_DOWN = 1'b1} phase_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int W   = 12,
  parameter int NCH = 3,
  parameter int SW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SW-1:0]         wr_sel,
  input  logic [W-1:0]          wr_data,
  input  logic                  run,
  input  logic                  load,
  output logic [W-1:0]          act_per,
  output logic [W-1:0]          sh_per,
  output logic [W-1:0]          act_dead,
  output logic [NCH-1:0][W-1:0] act_duty,
  output logic                  en
);
  logic [W-1:0]   sh_dead;
  logic           got_per;
  logic [NCH-1:0] got_duty;
  logic           per_wr, dead_wr;

  assign per_wr  = wr_en && (wr_sel == SW'(SEL_PERIOD));
  assign dead_wr = wr_en && (wr_sel == SW'(SEL_DEAD));
  assign en      = got_per && (&got_duty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_per  <= '0;
      sh_per   <= '0;
      act_dead <= '0;
      sh_dead  <= '0;
      got_per  <= 1'b0;
    end else begin
      if (load) begin
        act_per  <= sh_per;
        act_dead <= sh_dead;
      end
      if (per_wr) begin
        sh_per  <= wr_data;
        got_per <= 1'b1;
        if (!run) act_per <= wr_data;
      end
      if (dead_wr) begin
        sh_dead <= wr_data;
        if (!en) act_dead <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_duty
    logic [W-1:0] sh_duty;
    logic         duty_wr;
    assign duty_wr = wr_en && (wr_sel == SW'(SEL_DUTY_BASE + i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_duty     <= '0;
        act_duty[i] <= '0;
        got_duty[i] <= 1'b0;
      end else begin
        if (load) act_duty[i] <= sh_duty;
        if (duty_wr) begin
          sh_duty     <= wr_data;
          got_duty[i] <= 1'b1;
          if (!en) act_duty[i] <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/cpwm_tbase.sv
module cpwm_tbase
  import cpwm_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dbl_mode,
  input  logic         start,
  input  logic [W-1:0] start_per,
  input  logic [W-1:0] act_per,
  input  logic [W-1:0] down_per,
  output logic [W-1:0] cnt,
  output phase_e       phase,
  output logic         run,
  output logic         sync_q,
  output logic         step_start,
  output logic         step_mid
);
  logic [W-1:0] pre;
  logic         adv;

  assign adv        = run && !start && (pre == '0);
  assign step_mid   = adv && (phase == PH_UP) && (cnt == act_per - 1'b1);
  assign step_start = adv && (phase == PH_DOWN) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      phase  <= PH_UP;
      cnt    <= '0;
      pre    <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= 1'b0;
      if (start) begin
        run   <= 1'b1;
        phase <= PH_DOWN;
        cnt   <= start_per - 1'b1;
        pre   <= dbl_mode ? '0 : (start_per >> 1);
      end else if (run) begin
        if (pre != '0) begin
          pre <= pre - 1'b1;
        end else if (phase == PH_UP) begin
          if (step_mid) begin
            phase <= PH_DOWN;
            cnt   <= down_per - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          if (step_start) begin
            phase  <= PH_UP;
            sync_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < act_per));
  // R6
  sync_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (phase == PH_UP && cnt == '0));
  // R9
  mid_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase) |-> (cnt == act_per - 1'b1));
endmodule

// File: rtl/cpwm_cmp.sv
module cpwm_cmp #(
  parameter int W   = 12,
  parameter int NCH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [W-1:0]          cnt,
  input  logic [W-1:0]          per,
  input  logic [W-1:0]          dead,
  input  logic [NCH-1:0][W-1:0] duty,
  output logic [NCH-1:0]        hi,
  output logic [NCH-1:0]        lo
);
  localparam int XW = W + 3;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic signed [XW-1:0] base, hi_m, lo_m;
    assign base = $signed({3'b000, cnt}) + $signed({3'b000, duty[i]})
                - $signed({3'b000, per});
    assign hi_m = base - $signed({3'b000, dead});
    assign lo_m = base + $signed({3'b000, dead});
    assign hi[i] = en && (hi_m >= 0);
    assign lo[i] = en && (lo_m < 0);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi[i] && lo[i]));
  end
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top
  import cpwm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int W   = 12,
  localparam int SW = $clog2(NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dbl_mode,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [W-1:0]   wr_data,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo,
  output logic           sync_pulse,
  output logic           half_flag
);
  logic [W-1:0]          act_per, sh_per, act_dead, down_per, cnt;
  logic [NCH-1:0][W-1:0] act_duty;
  logic                  en, run, sync_q, step_start, step_mid, load, start;
  phase_e                phase;

  assign start    = wr_en && (wr_sel == SW'(SEL_PERIOD)) && !run;
  assign load     = step_start || (step_mid && dbl_mode);
  assign down_per = dbl_mode ? sh_per : act_per;

  cpwm_regs #(.W(W), .NCH(NCH), .SW(SW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(run), .load(load), .act_per(act_per), .sh_per(sh_per),
    .act_dead(act_dead), .act_duty(act_duty), .en(en)
  );

  cpwm_tbase #(.W(W)) tbase_i (
    .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .start(start),
    .start_per(wr_data), .act_per(act_per), .down_per(down_per),
    .cnt(cnt), .phase(phase), .run(run), .sync_q(sync_q),
    .step_start(step_start), .step_mid(step_mid)
  );

  cpwm_cmp #(.W(W), .NCH(NCH)) cmp_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .per(act_per),
    .dead(act_dead), .duty(act_duty), .hi(pwm_hi), .lo(pwm_lo)
  );

  assign sync_pulse = en && sync_q;
  assign half_flag  = en && (phase == PH_DOWN);

  // R8
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !dbl_mode && !$past(dbl_mode) && !$stable(act_per))
      |-> sync_pulse);
endmodule

// File: tb/cpwm3_top_tb_top.sv
`timescale 1ns/1ps
module cpwm3_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbl_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  pwm_hi, pwm_lo;
  logic        sync_pulse, half_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpwm3_top dut_i (
    .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .sync_pulse(sync_pulse), .half_flag(half_flag)
  );

  // P, T, D0, D1, D2, hi0, hi1, hi2, lo0, lo1, lo2 (counts per period)
  localparam int NV = 4;
  localparam int VEC [NV][11] = '{
    '{20, 2, 10,  5,  1, 16,  6,  0, 16, 26, 34},
    '{16, 0,  0,  8, 16,  0, 16, 32, 32, 16,  0},
    '{10, 3, 12,  2,  7, 18,  0,  8,  0, 10,  0},
    '{24, 1, 30, 12,  3, 48, 22,  4,  0, 22, 40}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = val[11:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_sync(output int n);
    n = 0;
    while (!sync_pulse && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic config5(input int p, input int t, input int d0, input int d1, input int d2);
    wr(0, p); wr(1, t); wr(2, d0); wr(3, d1); wr(4, d2);
  endtask

  initial begin
    int n, hi0, rise;
    longint tw;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {pwm_hi, pwm_lo, sync_pulse, half_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R6 vector walk, single-update mode
    for (int v = 0; v < NV; v++) begin
      int p;
      int hic[3];
      int loc[3];
      int hc;
      p = VEC[v][0];
      do_reset();
      dbl_mode = 1'b0;
      config5(p, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      wait_sync(n);
      hic = '{0, 0, 0}; loc = '{0, 0, 0}; hc = 0;
      for (int k = 0; k < 2 * p; k++) begin
        for (int c = 0; c < 3; c++) begin
          hic[c] += int'(pwm_hi[c]);
          loc[c] += int'(pwm_lo[c]);
        end
        hc += int'(half_flag);
        if (k < p && half_flag) hc += 1000;
        @(negedge clk);
      end
      for (int c = 0; c < 3; c++) begin
        chk($sformatf("R3 vec%0d hi ch%0d", v, c), hic[c], VEC[v][5 + c]);
        chk($sformatf("R4 vec%0d lo ch%0d", v, c), loc[c], VEC[v][8 + c]);
      end
      chk($sformatf("R6 vec%0d half flag cycles", v), hc, p);
      chk($sformatf("R6 vec%0d sync after 2P", v), int'(sync_pulse), 1);
    end

    // R1: reset while running
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset while running", {pwm_hi, pwm_lo, sync_pulse, half_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: hold until all enabling writes
    do_reset();
    wr(0, 20); wr(1, 2); wr(2, 10); wr(3, 8);
    n = 0;
    for (int k = 0; k < 80; k++) begin
      if ({pwm_hi, pwm_lo, sync_pulse, half_flag} != 0) n++;
      @(negedge clk);
    end
    chk("R2 outputs held before last duty", n, 0);
    wr(4, 6);
    wait_sync(n);
    chk("R2 sync appears after enable", int'(sync_pulse), 1);

    // R7: startup delay, single then double
    for (int m = 0; m < 2; m++) begin
      do_reset();
      dbl_mode = m[0];
      tw = $time;
      wr(0, 20); wr(1, 1); wr(2, 5); wr(3, 5); wr(4, 5);
      wait_sync(n);
      chk(m == 0 ? "R7 single startup" : "R7 double startup",
          int'(($time - tw - 4) / 4), m == 0 ? 30 : 20);
    end

    // R8: single-update, write lands at next period start
    do_reset();
    dbl_mode = 1'b0;
    config5(20, 0, 10, 10, 10);
    wait_sync(n);
    wr(0, 10);
    n = 1;
    while (!sync_pulse && n < 200) begin @(negedge clk); n++; end
    chk("R8 old period kept", n, 40);
    @(negedge clk);
    n = 1;
    while (!sync_pulse && n < 200) begin @(negedge clk); n++; end
    chk("R8 new period after start", n, 20);

    // R9: double-update, second half uses new values
    do_reset();
    dbl_mode = 1'b1;
    config5(20, 0, 10, 10, 10);
    wait_sync(n);
    hi0 = 0; rise = -1; n = -1;
    for (int k = 0; k < 200; k++) begin
      if (k == 0) begin wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'd10; end
      if (k == 1) begin wr_en = 1'b1; wr_sel = 3'd2; wr_data = 12'd10; end
      if (k == 2) wr_en = 1'b0;
      if (k > 0 && sync_pulse) begin n = k; break; end
      if (half_flag && rise < 0) rise = k;
      hi0 += int'(pwm_hi[0]);
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R9 half flag rise", rise, 20);
    chk("R9 period length", n, 30);
    chk("R9 hi ch0 cycles", hi0, 20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule